// File: doc/BRIEF.md
# CAN Serial-Tunnel Node Controller

This block turns a frame-level CAN controller into a byte-stream serial port for one node on a shared bus. Frames arrive from the controller as an 11-bit standard identifier, a 4-bit length and eight data bytes. Outgoing frames leave in the same shape through a valid/ready handshake. Bit timing, arbitration, CRC and acceptance filtering are handled elsewhere.

The node has no bus address after reset. It folds a 96-bit unique value into a 48-bit short identity. It announces that identity once, and again whenever a host queries it, until the host binds an address to that identity. Once it has an address, the node answers pings and honours a host-issued reset command. Payload bytes of frames sent to its address go out on a receive byte stream. Bytes pulled from a transmit byte stream are packed into frames of up to eight bytes.

Top module: `can_tunnel_node`

## Requirements
- R1: Synchronous active-high reset clears the address to zero. After reset a hello frame is sent once: identifier 0x323, length 6, data bytes 0..5 equal to the short identity and bytes 6..7 zero. Short identity byte i is uniqueId byte i XOR uniqueId byte i+6, where byte k of a vector is bits 8k+7:8k. The same byte placement applies to every data field.
- R2: While unaddressed, a frame on the query identifier 0x321 with length 0 produces the identity frame of R1. A query frame with nonzero length produces nothing.
- R3: While unaddressed, a frame on the set-address identifier (parameter, default 0x322) is taken only when data bytes 2..7 equal the short identity bytes 0..5. The address then becomes byte0 + 256*byte1.
- R4: Once addressed, a length-0 frame whose identifier equals the address is answered by a length-0 frame with all-zero data on identifier address+1.
- R5: Once addressed, a frame on the address with length n>0 sends data bytes 0..n-1, in order, to the receive byte stream. A length above 8 counts as 8.
- R6: Once addressed, a query-identifier frame with nonzero length whose bytes 0 and 1 equal the address raises resetReq for exactly one cycle. A mismatch raises nothing.
- R7: Transmit bytes are packed into frames on identifier address+1. Each frame carries up to 8 bytes, its length equals the number of bytes collected, and unused bytes are zero. A partial frame is sent when the byte stream is empty for one cycle. No frame is sent when no bytes were collected.
- R8: While the address is zero, no transmit byte is taken and no data frame is sent.
- R9: Frames whose identifier matches no rule for the current state are consumed without effect. Once addressed, this includes length-0 queries and set-address frames.
- R10: An offered frame is held stable until txReady. An offered receive byte is held stable until outByteReady. Each incoming frame is consumed exactly once, in a cycle with rxValid and rxReady both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uniqueId | input | 96 | Unique device value folded into the short identity |
| rxValid | input | 1 | Incoming frame offered |
| rxReady | output | 1 | Incoming frame consumed this cycle |
| rxId | input | 11 | Incoming frame identifier |
| rxLen | input | 4 | Incoming frame length |
| rxData | input | 64 | Incoming frame data, byte k at bits 8k+7:8k |
| txValid | output | 1 | Outgoing frame offered |
| txReady | input | 1 | Outgoing frame taken |
| txId | output | 11 | Outgoing frame identifier |
| txLen | output | 4 | Outgoing frame length |
| txData | output | 64 | Outgoing frame data |
| outByteValid | output | 1 | Receive-stream byte offered |
| outByteReady | input | 1 | Receive-stream byte taken |
| outByte | output | 8 | Receive-stream byte |
| inByteValid | input | 1 | Transmit-stream byte available (not empty) |
| inByte | input | 8 | Transmit-stream head byte |
| inByteTake | output | 1 | Pops the transmit-stream head this cycle |
| resetReq | output | 1 | One-cycle host reset request |

## Verification
A frame is consumed in the cycle where rxReady is high, and its response follows one clock later. A ping or identity reply appears on txValid in that next cycle, as do the first forwarded byte on outByteValid and the resetReq pulse. A transmit burst spends one cycle leaving idle, then takes one byte per cycle. It offers the frame on the cycle after the eighth byte, or after the first empty cycle. The ready inputs are randomized, so exact cycles vary. The bench records every handshake half a cycle before the edge that completes it. It compares the recorded frames, bytes and pulses only after a settle window longer than the worst-case latency, and it also checks that nothing further arrived.

// File: rtl/can_tunnel_pkg.sv
package can_tunnel_pkg;
  localparam int IdW        = 11;
  localparam int LenW       = 4;
  localparam int MaxBytes   = 8;
  localparam int DataW      = MaxBytes * 8;
  localparam int ShortBytes = 6;
  localparam int ShortW     = ShortBytes * 8;
  localparam int UidW       = 2 * ShortW;
  localparam int AddrW      = 16;

  // strobes from control to datapath
  typedef struct packed {
    logic loadIdent;
    logic loadPing;
    logic loadAddr;
    logic latchRx;
    logic stepOut;
    logic clrBurst;
    logic pushByte;
    logic loadBurst;
  } ctlStrobes_t;

  typedef enum logic [2:0] {
    RX_NONE, RX_QUERY, RX_SETADDR, RX_PING, RX_DATA, RX_RESET
  } rxKind_t;
endpackage

// File: rtl/can_tunnel_dp.sv
module can_tunnel_dp
  import can_tunnel_pkg::*;
#(
  parameter logic [IdW-1:0] QUERY_ID   = 11'h321,
  parameter logic [IdW-1:0] RESP_ID    = 11'h323,
  parameter logic [IdW-1:0] SETADDR_ID = 11'h322
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       st,
  input  logic [UidW-1:0]   uniqueId,
  input  logic [IdW-1:0]    rxId,
  input  logic [LenW-1:0]   rxLen,
  input  logic [DataW-1:0]  rxData,
  input  logic [7:0]        inByte,
  output rxKind_t           rxKind,
  output logic              addressed,
  output logic              fwdLast,
  output logic [LenW-1:0]   burstCnt,
  output logic [IdW-1:0]    txId,
  output logic [LenW-1:0]   txLen,
  output logic [DataW-1:0]  txData,
  output logic [7:0]        outByte
);
  logic [AddrW-1:0]  nodeAddr;
  logic [ShortW-1:0] shortId;
  logic [DataW-1:0]  fwdData;
  logic [LenW-1:0]   fwdLen;
  logic [LenW-1:0]   fwdIdx;
  logic [IdW-1:0]    replyId;
  logic              idMatch;

  for (genvar gi = 0; gi < ShortBytes; gi++) begin : g_fold
    assign shortId[gi*8 +: 8] = uniqueId[gi*8 +: 8] ^ uniqueId[(gi+ShortBytes)*8 +: 8];
  end

  assign addressed = (nodeAddr != '0);
  assign replyId   = nodeAddr[IdW-1:0] + 11'd1;
  assign idMatch   = (nodeAddr[AddrW-1:IdW] == '0) && (nodeAddr[IdW-1:0] == rxId);
  assign fwdLast   = (fwdIdx == fwdLen - 4'd1);
  assign outByte   = fwdData[fwdIdx[2:0]*8 +: 8];

  always_comb begin
    rxKind = RX_NONE;
    if (!addressed) begin
      if (rxId == QUERY_ID && rxLen == '0)
        rxKind = RX_QUERY;
      else if (rxId == SETADDR_ID && rxData[DataW-1:16] == shortId)
        rxKind = RX_SETADDR;
    end else begin
      if (idMatch)
        rxKind = (rxLen == '0) ? RX_PING : RX_DATA;
      else if (rxId == QUERY_ID && rxLen != '0 && rxData[AddrW-1:0] == nodeAddr)
        rxKind = RX_RESET;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nodeAddr <= '0;
      txId     <= '0;
      txLen    <= '0;
      txData   <= '0;
      fwdData  <= '0;
      fwdLen   <= '0;
      fwdIdx   <= '0;
      burstCnt <= '0;
    end else begin
      if (st.loadAddr) nodeAddr <= rxData[AddrW-1:0];
      if (st.loadIdent) begin
        txId   <= RESP_ID;
        txLen  <= LenW'(ShortBytes);
        txData <= {{(DataW-ShortW){1'b0}}, shortId};
      end
      if (st.loadPing) begin
        txId   <= replyId;
        txLen  <= '0;
        txData <= '0;
      end
      if (st.clrBurst) begin
        burstCnt <= '0;
        txData   <= '0;
      end
      if (st.pushByte) begin
        txData[burstCnt[2:0]*8 +: 8] <= inByte;
        burstCnt <= burstCnt + 4'd1;
      end
      if (st.loadBurst) begin
        txId  <= replyId;
        txLen <= burstCnt + LenW'(st.pushByte);
      end
      if (st.latchRx) begin
        fwdData <= rxData;
        fwdLen  <= (rxLen > LenW'(MaxBytes)) ? LenW'(MaxBytes) : rxLen;
        fwdIdx  <= '0;
      end
      if (st.stepOut) fwdIdx <= fwdIdx + 4'd1;
    end
  end

  // R3: the address only moves on an accepted set-address frame
  a_r3_addr_only_on_set: assert property (@(posedge clk) disable iff (rst)
    !$stable(nodeAddr) |-> ($past(st.loadAddr) || $past(rst)));
endmodule

// File: rtl/can_tunnel_ctrl.sv
module can_tunnel_ctrl
  import can_tunnel_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            rxValid,
  input  logic            txReady,
  input  logic            outByteReady,
  input  logic            inByteValid,
  input  rxKind_t         rxKind,
  input  logic            addressed,
  input  logic            fwdLast,
  input  logic [LenW-1:0] burstCnt,
  output ctlStrobes_t     st,
  output logic            rxReady,
  output logic            txValid,
  output logic            outByteValid,
  output logic            inByteTake,
  output logic            resetReq
);
  typedef enum logic [1:0] {S_IDLE, S_SEND, S_FWD, S_FILL} state_t;

  state_t state, nxt;
  logic   helloPend, helloClr, fire;

  always_comb begin
    st           = '0;
    nxt          = state;
    rxReady      = 1'b0;
    inByteTake   = 1'b0;
    helloClr     = 1'b0;
    fire         = 1'b0;
    txValid      = (state == S_SEND);
    outByteValid = (state == S_FWD);
    case (state)
      S_IDLE: begin
        if (helloPend) begin
          st.loadIdent = 1'b1;
          helloClr     = 1'b1;
          nxt          = S_SEND;
        end else if (rxValid) begin
          rxReady = 1'b1;
          case (rxKind)
            RX_QUERY:   begin st.loadIdent = 1'b1; nxt = S_SEND; end
            RX_SETADDR: st.loadAddr = 1'b1;
            RX_PING:    begin st.loadPing = 1'b1; nxt = S_SEND; end
            RX_DATA:    begin st.latchRx = 1'b1; nxt = S_FWD; end
            RX_RESET:   fire = 1'b1;
            default:    ;
          endcase
        end else if (addressed && inByteValid) begin
          st.clrBurst = 1'b1;
          nxt         = S_FILL;
        end
      end
      S_SEND: if (txReady) nxt = S_IDLE;
      S_FWD: begin
        if (outByteReady) begin
          st.stepOut = 1'b1;
          if (fwdLast) nxt = S_IDLE;
        end
      end
      S_FILL: begin
        if (inByteValid) begin
          inByteTake  = 1'b1;
          st.pushByte = 1'b1;
          if (burstCnt == LenW'(MaxBytes - 1)) begin
            st.loadBurst = 1'b1;
            nxt          = S_SEND;
          end
        end else if (burstCnt != '0) begin
          st.loadBurst = 1'b1;
          nxt          = S_SEND;
        end else begin
          nxt = S_IDLE;
        end
      end
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      helloPend <= 1'b1;
      resetReq  <= 1'b0;
    end else begin
      state    <= nxt;
      resetReq <= fire;
      if (helloClr) helloPend <= 1'b0;
    end
  end

  // R8: bytes are only popped by an addressed node from a non-empty stream
  a_r8_take_needs_addr: assert property (@(posedge clk) disable iff (rst)
    inByteTake |-> (addressed && inByteValid));
  // R6: a reset pulse always follows a consumed frame
  a_r6_reset_after_accept: assert property (@(posedge clk) disable iff (rst)
    resetReq |-> $past(rxValid && rxReady));
endmodule

// File: rtl/can_tunnel_node.sv
module can_tunnel_node
  import can_tunnel_pkg::*;
#(
  parameter logic [IdW-1:0] QUERY_ID   = 11'h321,
  parameter logic [IdW-1:0] RESP_ID    = 11'h323,
  parameter logic [IdW-1:0] SETADDR_ID = 11'h322
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [UidW-1:0]  uniqueId,
  input  logic             rxValid,
  output logic             rxReady,
  input  logic [IdW-1:0]   rxId,
  input  logic [LenW-1:0]  rxLen,
  input  logic [DataW-1:0] rxData,
  output logic             txValid,
  input  logic             txReady,
  output logic [IdW-1:0]   txId,
  output logic [LenW-1:0]  txLen,
  output logic [DataW-1:0] txData,
  output logic             outByteValid,
  input  logic             outByteReady,
  output logic [7:0]       outByte,
  input  logic             inByteValid,
  input  logic [7:0]       inByte,
  output logic             inByteTake,
  output logic             resetReq
);
  ctlStrobes_t     st;
  rxKind_t         rxKind;
  logic            addressed;
  logic            fwdLast;
  logic [LenW-1:0] burstCnt;

  can_tunnel_ctrl i_ctrl (
    .clk(clk), .rst(rst), .rxValid(rxValid), .txReady(txReady),
    .outByteReady(outByteReady), .inByteValid(inByteValid), .rxKind(rxKind),
    .addressed(addressed), .fwdLast(fwdLast), .burstCnt(burstCnt), .st(st),
    .rxReady(rxReady), .txValid(txValid), .outByteValid(outByteValid),
    .inByteTake(inByteTake), .resetReq(resetReq)
  );

  can_tunnel_dp #(
    .QUERY_ID(QUERY_ID), .RESP_ID(RESP_ID), .SETADDR_ID(SETADDR_ID)
  ) i_dp (
    .clk(clk), .rst(rst), .st(st), .uniqueId(uniqueId), .rxId(rxId),
    .rxLen(rxLen), .rxData(rxData), .inByte(inByte), .rxKind(rxKind),
    .addressed(addressed), .fwdLast(fwdLast), .burstCnt(burstCnt),
    .txId(txId), .txLen(txLen), .txData(txData), .outByte(outByte)
  );

  // R10: offered frame held until taken
  a_r10_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (txValid && !txReady) |=> (txValid && $stable(txId) && $stable(txLen) && $stable(txData)));
  // R10: offered receive byte held until taken
  a_r10_out_hold: assert property (@(posedge clk) disable iff (rst)
    (outByteValid && !outByteReady) |=> (outByteValid && $stable(outByte)));
  // R7: no frame longer than eight bytes
  a_r7_len_cap: assert property (@(posedge clk) disable iff (rst)
    txValid |-> (txLen <= 4'd8));
endmodule

// File: tb/test_can_tunnel_node.sv
`timescale 1ns/1ps
module test_can_tunnel_node;
  localparam logic [10:0] QID = 11'h321;
  localparam logic [10:0] RID = 11'h323;
  localparam logic [10:0] SID = 11'h322;
  localparam logic [95:0] UID = 96'h0123_4567_89AB_CDEF_F0E1_D2C3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, rxValid, rxReady, txValid, txReady, outByteValid, outByteReady;
  logic        inByteValid, inByteTake, resetReq;
  logic [10:0] rxId, txId;
  logic [3:0]  rxLen, txLen;
  logic [63:0] rxData, txData;
  logic [7:0]  outByte, inByte;

  can_tunnel_node i_can_tunnel_node (
    .clk(clk), .rst(rst), .uniqueId(UID), .rxValid(rxValid), .rxReady(rxReady),
    .rxId(rxId), .rxLen(rxLen), .rxData(rxData), .txValid(txValid), .txReady(txReady),
    .txId(txId), .txLen(txLen), .txData(txData), .outByteValid(outByteValid),
    .outByteReady(outByteReady), .outByte(outByte), .inByteValid(inByteValid),
    .inByte(inByte), .inByteTake(inByteTake), .resetReq(resetReq)
  );

  logic [10:0] gotId[$];
  logic [3:0]  gotLen[$];
  logic [63:0] gotData[$];
  logic [7:0]  gotByte[$];
  logic [7:0]  srcQ[$];
  int nChecks = 0, nFail = 0, resetPulses = 0;
  logic pendingTake = 1'b0;
  logic done = 1'b0;

  function automatic logic [47:0] shortOf(logic [95:0] u);
    logic [47:0] r;
    for (int i = 0; i < 6; i++) r[i*8 +: 8] = u[i*8 +: 8] ^ u[(i+6)*8 +: 8];
    return r;
  endfunction

  // stream models and handshake monitor
  always @(negedge clk) begin
    if (pendingTake) void'(srcQ.pop_front());
    inByteValid  = (srcQ.size() > 0);
    inByte       = (srcQ.size() > 0) ? srcQ[0] : 8'h00;
    txReady      = ($urandom_range(0, 3) != 0);
    outByteReady = ($urandom_range(0, 3) != 0);
    #1;
    pendingTake = inByteTake;
    if (txValid && txReady) begin
      gotId.push_back(txId); gotLen.push_back(txLen); gotData.push_back(txData);
    end
    if (outByteValid && outByteReady) gotByte.push_back(outByte);
    if (resetReq) resetPulses++;
  end

  task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic expectFrame(input string req, input logic [10:0] id, input logic [3:0] len, input logic [63:0] data);
    if (gotId.size() == 0) begin
      nChecks++; nFail++;
      $display("FAIL %s frame: actual none expected id %h len %0d", req, id, len);
    end else begin
      chk(req, "id", 64'(gotId.pop_front()), 64'(id));
      chk(req, "len", 64'(gotLen.pop_front()), 64'(len));
      chk(req, "data", gotData.pop_front(), data);
    end
  endtask

  task automatic expectNoFrame(input string req);
    chk(req, "extra frames", 64'(gotId.size()), 64'd0);
    gotId.delete(); gotLen.delete(); gotData.delete();
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendFrame(input logic [10:0] id, input logic [3:0] len, input logic [63:0] data);
    @(negedge clk);
    rxValid = 1'b1; rxId = id; rxLen = len; rxData = data;
    #2;
    while (!rxReady) begin @(negedge clk); #2; end
    @(posedge clk); #1;
    rxValid = 1'b0;
  endtask

  task automatic pushBytes(input logic [7:0] b[$]);
    @(negedge clk); #1.5;
    foreach (b[i]) srcQ.push_back(b[i]);
  endtask

  task automatic expectBytes(input string req, input logic [63:0] data, input int n);
    chk(req, "byte count", 64'(gotByte.size()), 64'(n));
    for (int i = 0; i < n && gotByte.size() > 0; i++)
      chk(req, "byte", 64'(gotByte.pop_front()), 64'(data[i*8 +: 8]));
    gotByte.delete();
  endtask

  task automatic burstCheck(input string req, input int n);
    logic [7:0] b[$];
    for (int i = 0; i < n; i++) b.push_back(8'($urandom()));
    pushBytes(b);
    settle(40 + 12 * n);
    for (int f = 0; f * 8 < n; f++) begin
      logic [63:0] d = '0;
      int len = (n - f * 8 > 8) ? 8 : n - f * 8;
      for (int j = 0; j < len; j++) d[j*8 +: 8] = b[f*8 + j];
      expectFrame(req, 11'h046, 4'(len), d);
    end
    expectNoFrame(req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    logic [47:0] sid;
    logic [63:0] hello;
    logic [7:0]  b3[$];
    void'($urandom(32'h5EED_0042));
    sid   = shortOf(UID);
    hello = {16'h0, sid};
    rst = 1'b1; rxValid = 1'b0; rxId = '0; rxLen = '0; rxData = '0;
    settle(3); #1;
    // R1 reset state
    chk("R1", "txValid in reset", 64'(txValid), 64'd0);
    chk("R1", "rxReady in reset", 64'(rxReady), 64'd0);
    chk("R1", "resetReq in reset", 64'(resetReq), 64'd0);
    @(negedge clk); rst = 1'b0;
    settle(30);
    expectFrame("R1", RID, 4'd6, hello);
    expectNoFrame("R1");

    // R2 query
    sendFrame(QID, 4'd0, 64'h0); settle(20);
    expectFrame("R2", RID, 4'd6, hello);
    sendFrame(QID, 4'd3, 64'h1234); settle(20);
    expectNoFrame("R2");

    // R9 unrelated identifiers while unaddressed
    sendFrame(11'h045, 4'd2, 64'hAAAA); sendFrame(11'h100, 4'd0, 64'h0); settle(20);
    expectNoFrame("R9");
    chk("R9", "bytes out", 64'(gotByte.size()), 64'd0);

    // R8 no draining while unaddressed
    b3 = '{8'hA1, 8'hB2, 8'hC3};
    pushBytes(b3); settle(40);
    chk("R8", "pending bytes", 64'(srcQ.size()), 64'd3);
    expectNoFrame("R8");

    // R3 wrong identity rejected: still answers queries
    sendFrame(SID, 4'd8, {sid ^ 48'h1, 16'h0045}); settle(10);
    sendFrame(QID, 4'd0, 64'h0); settle(20);
    expectFrame("R3", RID, 4'd6, hello);
    // R3 correct identity, then R7/R8 the held bytes drain
    sendFrame(SID, 4'd8, {sid, 16'h0045}); settle(60);
    expectFrame("R7", 11'h046, 4'd3, {40'h0, 8'hC3, 8'hB2, 8'hA1});
    chk("R8", "drained", 64'(srcQ.size()), 64'd0);
    expectNoFrame("R7");

    // R4 ping
    sendFrame(11'h045, 4'd0, 64'hFFFF); settle(20);
    expectFrame("R4", 11'h046, 4'd0, 64'h0);

    // R9 addressed: query len0 and set-address ignored
    sendFrame(QID, 4'd0, 64'h0);
    sendFrame(SID, 4'd8, {sid, 16'h0077});
    sendFrame(11'h077, 4'd0, 64'h0); settle(30);
    expectNoFrame("R9");
    sendFrame(11'h045, 4'd0, 64'h0); settle(20);
    expectFrame("R9", 11'h046, 4'd0, 64'h0);

    // R5 forwarding, including over-length
    sendFrame(11'h045, 4'd5, 64'h8877_6655_4433_2211); settle(40);
    expectBytes("R5", 64'h8877_6655_4433_2211, 5);
    sendFrame(11'h045, 4'd12, 64'h0F0E_0D0C_0B0A_0908); settle(50);
    expectBytes("R5", 64'h0F0E_0D0C_0B0A_0908, 8);
    expectNoFrame("R5");

    // R6 reset command
    resetPulses = 0;
    sendFrame(QID, 4'd2, 64'h0045); settle(10);
    chk("R6", "pulses", 64'(resetPulses), 64'd1);
    sendFrame(QID, 4'd2, 64'h0046); sendFrame(QID, 4'd0, 64'h0045); settle(10);
    chk("R6", "pulses after mismatch", 64'(resetPulses), 64'd1);
    expectNoFrame("R6");

    // R7 directed: short burst, exactly eight, nine
    burstCheck("R7", 2);
    burstCheck("R7", 8);
    burstCheck("R7", 9);
    settle(20);
    expectNoFrame("R7");

    // R5/R10 random forwarding
    for (int k = 0; k < 20; k++) begin
      logic [63:0] d = {$urandom(), $urandom()};
      int n = $urandom_range(1, 8);
      sendFrame(11'h045, 4'(n), d); settle(40);
      expectBytes("R10", d, n);
    end
    // R7/R10 random bursts
    for (int k = 0; k < 10; k++) burstCheck("R7", $urandom_range(1, 30));

    // R1 mid-run reset
    @(negedge clk); rst = 1'b1; settle(2); rst = 1'b0;
    settle(30);
    expectFrame("R1", RID, 4'd6, hello);
    sendFrame(11'h045, 4'd0, 64'h0); settle(20);
    expectNoFrame("R1");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
    $finish;
  end
endmodule